// File: doc/BRIEF.md
# Masked Interrupt Cause Controller

This block collects 29 level-sensitive interrupt sources into a 32-bit cause register. Sources occupy bit positions 1 through 29. A source that is active in a cycle sets its cause bit, and the bit stays set until software clears it. A 32-bit enable register selects which latched causes may interrupt the processor. Software reads and writes both registers through a simple port that completes in one cycle. A write to the cause register clears every source bit written as 0.

Three positions of the cause register hold no storage. They read as hardware summaries that OR fixed, irregular groups of the raw source bits. The block also drives an interrupt line. Alongside the line it reports the index of the pending enabled source that wins arbitration, where the lowest index has the highest priority. Software can go straight to that source without scanning the register.

Top module: `irqc_top`

## Requirements
- R1: After reset the cause register reads 0, the enable register reads 0, `irq_o` is low, `pend_vld_o` is low and `pend_idx_o` is 0.
- R2: If source input `src_i[k-1]` is high at a clock edge, cause bit k (1..29) reads 1 after that edge. The bit stays 1 after the source input falls.
- R3: A write with `reg_addr`=0 (cause register) clears each cause bit 1..29 whose write-data bit is 0. Write-data bits that are 1 leave the cause bit unchanged.
- R4: If a source is active in the same cycle as a write that would clear its cause bit, the bit ends up set.
- R5: Cause bit 0 reads as the OR of raw cause bits 29..1, regardless of the enable register.
- R6: Cause bit 30 reads as the OR of raw cause bits 29..26 and 20..1.
- R7: Cause bit 31 reads as the OR of raw cause bits 25..1.
- R8: Writes to cause bits 0, 30 and 31 have no effect. Those positions always read as their summaries.
- R9: A write with `reg_addr`=1 (enable register) stores all 32 bits of `reg_wdata`. The stored value is readable, and it governs dispatch from the cycle after the write edge.
- R10: `irq_o` is high exactly when some bit k in 1..29 is set in both the cause and the enable registers. Enable bits 0, 30 and 31 have no effect on it.
- R11: `pend_vld_o` follows `irq_o`. When it is high, `pend_idx_o` is the lowest k (1..29) that is both caused and enabled. When it is low, `pend_idx_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_i | input | 29 | Level sources; bit k-1 drives cause bit k |
| reg_we | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Register select: 0 cause, 1 enable |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register, combinational |
| irq_o | output | 1 | Interrupt request |
| pend_vld_o | output | 1 | A pending enabled source exists |
| pend_idx_o | output | 5 | Index of the winning pending source |

## Verification
Source events, cause clears and enable writes all become visible one clock edge after the cycle in which they are presented. The interrupt line, the winning index and the read data are combinational from the registers, so they change together with that edge and have no further delay. The bench applies each stimulus in the half cycle before a rising edge. At the following falling edge it withdraws the stimulus, selects the register to read and samples every output a moment later. That sample is exactly one edge after the stimulus and before the next one.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_W    = 32;
    localparam int SRC_LO   = 1;
    localparam int SRC_HI   = 29;
    localparam int SRC_N    = SRC_HI - SRC_LO + 1;
    localparam int IDX_W    = $clog2(SRC_HI + 1);

    // positions of the read-only summary bits
    localparam int SUM_ANY_POS = 0;
    localparam int SUM_A_POS   = 30;
    localparam int SUM_B_POS   = 31;

    typedef enum logic {
        SEL_CAUSE  = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;

    function automatic logic [REG_W-1:0] bit_span(input int hi, input int lo);
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < REG_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    localparam logic [REG_W-1:0] GRP_ANY = bit_span(SRC_HI, SRC_LO);
    localparam logic [REG_W-1:0] GRP_A   = bit_span(29, 26) | bit_span(20, 1);
    localparam logic [REG_W-1:0] GRP_B   = bit_span(25, 1);

endpackage

// File: rtl/irqc_cause_reg.sv
module irqc_cause_reg
    import irqc_pkg::*;
#(
    parameter int N = SRC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_i,
    input  logic         clr_en_i,
    input  logic [N-1:0] keep_i,
    output logic [N-1:0] cause_o
);

    typedef struct packed {
        logic [N-1:0] cause;
    } cause_st_t;

    cause_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            // an active source outranks a clear in the same cycle
            st_d.cause[i] = src_i[i] | (st_q.cause[i] & ~(clr_en_i & ~keep_i[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_o = st_q.cause;

endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
    import irqc_pkg::*;
#(
    parameter int N = SRC_N,
    localparam int W = N + 3
) (
    input  logic [N-1:0] raw_i,
    output logic [W-1:0] view_o
);

    logic [W-1:0] placed;
    logic         any_s, grp_a_s, grp_b_s;

    always_comb begin
        placed  = {2'b00, raw_i, 1'b0};
        any_s   = |(placed & GRP_ANY);
        grp_a_s = |(placed & GRP_A);
        grp_b_s = |(placed & GRP_B);
        view_o  = placed;
        view_o[SUM_ANY_POS] = any_s;
        view_o[SUM_A_POS]   = grp_a_s;
        view_o[SUM_B_POS]   = grp_b_s;
    end

endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc
    import irqc_pkg::*;
#(
    parameter int N    = SRC_N,
    parameter int BASE = SRC_LO,
    parameter int IW   = IDX_W
) (
    input  logic [N-1:0]  pend_i,
    output logic          vld_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        // scan downward so the lowest pending index is written last
        for (int i = N - 1; i >= 0; i--) begin
            if (pend_i[i]) begin
                vld_o = 1'b1;
                idx_o = IW'(i + BASE);
            end
        end
    end

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_i,
    input  logic             reg_we,
    input  logic             reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_o,
    output logic             pend_vld_o,
    output logic [IDX_W-1:0] pend_idx_o
);

    typedef struct packed {
        logic [REG_W-1:0] en;
    } en_st_t;

    en_st_t           en_d, en_q;
    logic [SRC_N-1:0] cause_q;
    logic [REG_W-1:0] mask_q;
    logic [REG_W-1:0] cause_view;
    logic [SRC_N-1:0] pend_s;
    logic             wr_cause, wr_en;

    assign wr_cause = reg_we & (reg_sel_e'(reg_addr) == SEL_CAUSE);
    assign wr_en    = reg_we & (reg_sel_e'(reg_addr) == SEL_ENABLE);

    irqc_cause_reg #(.N(SRC_N)) cause_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (src_i),
        .clr_en_i (wr_cause),
        .keep_i   (reg_wdata[SRC_HI:SRC_LO]),
        .cause_o  (cause_q)
    );

    always_comb begin
        en_d = en_q;
        if (wr_en) en_d.en = reg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign mask_q = en_q.en;

    irqc_summary #(.N(SRC_N)) summary_i (
        .raw_i  (cause_q),
        .view_o (cause_view)
    );

    assign pend_s = cause_q & mask_q[SRC_HI:SRC_LO];

    irqc_prio_enc #(.N(SRC_N), .BASE(SRC_LO), .IW(IDX_W)) enc_i (
        .pend_i (pend_s),
        .vld_o  (pend_vld_o),
        .idx_o  (pend_idx_o)
    );

    assign irq_o     = |pend_s;
    assign reg_rdata = (reg_sel_e'(reg_addr) == SEL_ENABLE) ? mask_q : cause_view;

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk
    import irqc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_N-1:0] src_i,
    input logic             reg_we,
    input logic             reg_addr,
    input logic [REG_W-1:0] reg_wdata,
    input logic [SRC_N-1:0] cause_q,
    input logic [REG_W-1:0] mask_q,
    input logic             irq_o,
    input logic             pend_vld_o,
    input logic [IDX_W-1:0] pend_idx_o
);

    // R2
    src_sets_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause_q & $past(src_i)) == $past(src_i)));

    // R3
    cause_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> (cause_q == ($past(cause_q) | $past(src_i))));

    // R9
    enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr) |=> (mask_q == $past(reg_wdata)));

    // R11
    vld_follows_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld_o == irq_o);

    // R11
    idx_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_vld_o |-> (pend_idx_o >= IDX_W'(SRC_LO) && pend_idx_o <= IDX_W'(SRC_HI)
                        && cause_q[pend_idx_o - IDX_W'(SRC_LO)] && mask_q[pend_idx_o]));

    // R11
    idx_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_vld_o |-> (pend_idx_o == '0));

endmodule

bind irqc_top irqc_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_i      (src_i),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .cause_q    (cause_q),
    .mask_q     (mask_q),
    .irq_o      (irq_o),
    .pend_vld_o (pend_vld_o),
    .pend_idx_o (pend_idx_o)
);

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [28:0] src_i = '0;
    logic        reg_we = 1'b0;
    logic        reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;
    logic        pend_vld_o;
    logic [4:0]  pend_idx_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irqc_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_o      (irq_o),
        .pend_vld_o (pend_vld_o),
        .pend_idx_o (pend_idx_o)
    );

    typedef struct packed {
        logic [28:0] src;
        logic        we;
        logic        addr;
        logic [31:0] wdata;
        logic        rd_addr;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [4:0]  exp_idx;
    } vec_t;

    // addr 0 = cause register, 1 = enable register
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{29'h0,        1'b1, 1'b1, 32'hFFFFFFFF, 1'b1, 32'hFFFFFFFF, 1'b0, 5'd0},  // R9
        '{29'h10,       1'b0, 1'b0, 32'h0,        1'b0, 32'hC0000021, 1'b1, 5'd5},  // R2 R5 R6 R7
        '{29'h200000,   1'b0, 1'b0, 32'h0,        1'b0, 32'hC0400021, 1'b1, 5'd5},  // R11
        '{29'h0,        1'b1, 1'b0, 32'hFFFFFFDF, 1'b0, 32'h80400001, 1'b1, 5'd22}, // R3 R6
        '{29'h4000000,  1'b0, 1'b0, 32'h0,        1'b0, 32'hC8400001, 1'b1, 5'd22}, // R6
        '{29'h4000000,  1'b1, 1'b0, 32'h0,        1'b0, 32'h48000001, 1'b1, 5'd27}, // R4 R7
        '{29'h0,        1'b1, 1'b1, 32'hC0000001, 1'b1, 32'hC0000001, 1'b0, 5'd0},  // R10
        '{29'h0,        1'b1, 1'b0, 32'hFFFFFFFF, 1'b0, 32'h48000001, 1'b0, 5'd0},  // R3 R8
        '{29'h0,        1'b1, 1'b1, 32'h08000000, 1'b0, 32'h48000001, 1'b1, 5'd27}, // R9 R10
        '{29'h0,        1'b1, 1'b0, 32'h7FFFFFFE, 1'b0, 32'h48000001, 1'b1, 5'd27}, // R8
        '{29'h0,        1'b1, 1'b0, 32'h0,        1'b0, 32'h00000000, 1'b0, 5'd0},  // R3 R5
        '{29'h1FFFFFFF, 1'b0, 1'b0, 32'h0,        1'b0, 32'hFFFFFFFF, 1'b1, 5'd27}, // R10
        '{29'h0,        1'b1, 1'b1, 32'hFFFFFFFF, 1'b0, 32'hFFFFFFFF, 1'b1, 5'd1},  // R11
        '{29'h0,        1'b1, 1'b0, 32'hFFFFFFFD, 1'b0, 32'hFFFFFFFD, 1'b1, 5'd2},  // R11
        '{29'h0,        1'b1, 1'b0, 32'h20000000, 1'b0, 32'h60000001, 1'b1, 5'd29}  // R6 R7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req, input logic [31:0] rd, input logic irq,
                              input logic [4:0] idx);
        check({req, " rdata"}, reg_rdata, rd);
        check({req, " irq"}, {31'b0, irq_o}, {31'b0, irq});
        check({req, " vld"}, {31'b0, pend_vld_o}, {31'b0, irq});
        check({req, " idx"}, {27'b0, pend_idx_o}, {27'b0, idx});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state, both registers
        #1;
        reg_addr = 1'b0; #1;
        check_outs("R1 cause", 32'h0, 1'b0, 5'd0);
        reg_addr = 1'b1; #1;
        check("R1 enable", reg_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            src_i     = VECS[v].src;
            reg_we    = VECS[v].we;
            reg_addr  = VECS[v].addr;
            reg_wdata = VECS[v].wdata;
            @(negedge clk);
            src_i    = '0;
            reg_we   = 1'b0;
            reg_addr = VECS[v].rd_addr;
            #1;
            check_outs($sformatf("vec%0d", v), VECS[v].exp_rd, VECS[v].exp_irq, VECS[v].exp_idx);
        end

        // R2: a one-cycle pulse stays latched several cycles later
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b0; reg_wdata = 32'h0;
        @(negedge clk);
        reg_we = 1'b0;
        src_i = 29'h1;                       // cause bit 1
        @(negedge clk);
        src_i = '0;
        repeat (3) @(negedge clk);
        #1;
        check_outs("R2 hold", 32'hC0000003, 1'b1, 5'd1);

        // R9: enable write only visible after the edge
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 32'h0;
        #1;
        check("R9 before edge", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        reg_we = 1'b0;
        #1;
        check("R9 after edge", {31'b0, irq_o}, 32'h0);

        // R1: reset in mid-run clears both registers
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 1'b1; reg_wdata = 32'hFFFFFFFF;
        @(negedge clk);
        reg_we = 1'b0;
        rst_n = 1'b0;
        #1;
        reg_addr = 1'b1; #1;
        check("R1 enable cleared", reg_rdata, 32'h0);
        reg_addr = 1'b0; #1;
        check_outs("R1 cause cleared", 32'h0, 1'b0, 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule